// File: doc/BRIEF.md
# Destination Address Forwarding Filter

This block sits on the receive path of a small Ethernet port. It decides, for each received frame, whether the frame goes to the CPU port. The parser presents the 48-bit destination address together with a one-cycle strobe. One clock later the filter returns a valid pulse and a forward/drop bit.

The decision draws on an exact-match table with eight slots and on a few class overrides. The first two slots hold individual (unicast) station addresses. The remaining six slots hold group (multicast) addresses. Each slot has two flags: one arms the comparison and one allows forwarding, and a slot contributes only when both are set. A promiscuous switch forwards every frame. Separate switches pass every unicast frame, every non-broadcast multicast frame, or every broadcast frame. A master switch turns table matching on or off.

Software programs the block through a single-cycle write port with byte offsets. Address byte 0 is the first byte on the wire and is carried in `da[47:40]`. Its least significant bit, `da[40]`, is the individual/group bit.

Top module: `mac_da_filter`

## Requirements
- R1: After reset every slot is disarmed and every switch is clear, so every frame is dropped and `fwd_valid` is low until the first strobe.
- R2: `fwd_valid` is high in exactly the cycle after `da_valid` was high, and `fwd` is low whenever `fwd_valid` is low.
- R3: Slot i is written at byte offset 8*i (address bytes 2..5, with byte 2 in bits 31:24 and byte 5 in bits 7:0) and at offset 8*i+4 (byte 0 in bits 15:8, byte 1 in bits 7:0, arm flag in bit 17, forward flag in bit 21). The promiscuous switch is bit 7 at offset 0x40. At offset 0x44, bit 1 passes all unicast, bit 3 passes all multicast, bit 5 passes broadcast and bit 7 enables the table.
- R4: With the table enabled, a frame whose address equals a slot's full 48 bits is forwarded when that slot is armed and allowed to forward.
- R5: A slot that is armed but not allowed to forward, or allowed to forward but not armed, never causes forwarding.
- R6: With the table enable clear, slot contents have no effect on the decision.
- R7: Slots 0 and 1 match only addresses with `da[40]`=0, and slots 2 to 7 match only addresses with `da[40]`=1.
- R8: With the promiscuous switch set, every frame is forwarded.
- R9: The unicast switch forwards any address with `da[40]`=0. The multicast switch forwards any address with `da[40]`=1 that is not all ones. The broadcast switch forwards the all-ones address.
- R10: A register write in the same cycle as a strobe does not affect that strobe's decision. It takes effect from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write byte offset |
| wr_data | input | 32 | Write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 47:40 |
| fwd_valid | output | 1 | Decision valid, one cycle after the strobe |
| fwd | output | 1 | 1 = forward to CPU, 0 = drop |

## Verification
The assertions assume that `da` is stable and meaningful whenever `da_valid` is high. They also assume that the switch values sampled with a strobe are the ones the decision must use. For that reason they compare against the register state at the strobe edge, not after a write in the same cycle. The directed bench respects this by changing `da` only together with the strobe. It issues concurrent writes only in the one scenario that targets R10, where the expected result is the pre-write behaviour. Writes use only the defined offsets, with bits 1:0 of the offset at zero.

// File: rtl/mac_da_filter.sv
module mac_da_filter #(
  parameter int N_ENT = 8,
  parameter int N_UC  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(N_ENT)+3:0]      wr_addr,
  input  logic [31:0]                   wr_data,
  input  logic                          da_valid,
  input  logic [47:0]                   da,
  output logic                          fwd_valid,
  output logic                          fwd
);
  localparam int IDX_W  = $clog2(N_ENT);
  localparam int ADDR_W = IDX_W + 4;
  localparam int B_ARM  = 17;
  localparam int B_FWD  = 21;

  logic [47:0]      ent_addr [N_ENT];
  logic [N_ENT-1:0] ent_arm, ent_fwd, hit;
  logic             promisc, uc_all, mc_all, bc_all, tbl_en;

  wire              ctl_sel = wr_addr[ADDR_W-1];
  wire [IDX_W-1:0]  idx     = wr_addr[IDX_W+2:3];
  wire              hi_sel  = wr_addr[2];

  wire grp   = da[40];
  wire bcast = &da;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      promisc <= 1'b0;
      uc_all  <= 1'b0;
      mc_all  <= 1'b0;
      bc_all  <= 1'b0;
      tbl_en  <= 1'b0;
    end else if (wr_en && ctl_sel) begin
      if (!hi_sel) promisc <= wr_data[7];
      else begin
        uc_all <= wr_data[1];
        mc_all <= wr_data[3];
        bc_all <= wr_data[5];
        tbl_en <= wr_data[7];
      end
    end
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_addr[i] <= '0;
        ent_arm[i]  <= 1'b0;
        ent_fwd[i]  <= 1'b0;
      end else if (wr_en && !ctl_sel && idx == IDX_W'(i)) begin
        if (hi_sel) begin
          ent_addr[i][47:32] <= wr_data[15:0];
          ent_arm[i]         <= wr_data[B_ARM];
          ent_fwd[i]         <= wr_data[B_FWD];
        end else begin
          ent_addr[i][31:0]  <= wr_data;
        end
      end
    end

    if (i < N_UC) begin : g_uc
      assign hit[i] = ent_arm[i] & ent_fwd[i] & ~grp & (ent_addr[i] == da);
    end else begin : g_mc
      assign hit[i] = ent_arm[i] & ent_fwd[i] & grp & (ent_addr[i] == da);
    end
  end

  wire pass = promisc
            | (uc_all & ~grp)
            | (mc_all & grp & ~bcast)
            | (bc_all & bcast)
            | (tbl_en & |hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd       <= 1'b0;
    end else begin
      fwd_valid <= da_valid;
      fwd       <= da_valid & pass;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{wr_addr[1:0], wr_data[31:22], wr_data[20:18], wr_data[16],
                         wr_data[6], wr_data[4], wr_data[2], wr_data[0]};

  AST_LATENCY:   assert property (@(posedge clk) disable iff (!rst_n) da_valid |=> fwd_valid);  // R2
  AST_NO_SPUR:   assert property (@(posedge clk) disable iff (!rst_n) !da_valid |=> !fwd_valid); // R2
  AST_IDLE_LOW:  assert property (@(posedge clk) disable iff (!rst_n) !fwd_valid |-> !fwd);      // R2
  AST_PROMISC:   assert property (@(posedge clk) disable iff (!rst_n) da_valid && promisc |=> fwd); // R8
  AST_BCAST:     assert property (@(posedge clk) disable iff (!rst_n) da_valid && bc_all && bcast |=> fwd); // R9
  AST_HIT_FWD:   assert property (@(posedge clk) disable iff (!rst_n) da_valid && tbl_en && (hit != '0) |=> fwd); // R4
  AST_TABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
                   da_valid && !tbl_en && !promisc && !uc_all && !mc_all && !bc_all |=> !fwd); // R6
endmodule

// File: tb/sim_mac_da_filter.sv
module sim_mac_da_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        da_valid = 1'b0;
  logic [47:0] da = '0;
  logic        fwd_valid, fwd;
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [47:0] UA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] UB = 48'h02_aa_bb_cc_dd_ee;
  localparam logic [47:0] UC = 48'h00_10_20_30_40_50;
  localparam logic [47:0] UD = 48'h04_77_66_55_44_33;
  localparam logic [47:0] MA = 48'h01_00_5e_00_00_fb;
  localparam logic [47:0] MB = 48'h01_00_5e_11_22_33;
  localparam logic [47:0] BC = 48'hff_ff_ff_ff_ff_ff;

  mac_da_filter u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                    .wr_data(wr_data), .da_valid(da_valid), .da(da),
                    .fwd_valid(fwd_valid), .fwd(fwd));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ent(input int i, input logic [47:0] a, input logic arm, input logic fw);
    wr(7'(8*i), a[31:0]);
    wr(7'(8*i+4), {10'd0, fw, 3'd0, arm, 1'b0, a[47:32]});
  endtask

  task automatic classify(input logic [47:0] d, input logic exp, input string req);
    @(negedge clk);
    da_valid = 1'b1; da = d;
    @(negedge clk);
    da_valid = 1'b0;
    chk({req, " valid"}, fwd_valid, 1'b1);
    chk(req, fwd, exp);
  endtask

  task automatic t_reset;
    chk("R1 valid idle", fwd_valid, 1'b0);
    classify(BC, 1'b0, "R1 bcast after reset");
    classify(UA, 1'b0, "R1 unicast after reset");
    @(negedge clk);
    chk("R2 valid drops", fwd_valid, 1'b0);
    chk("R2 fwd low idle", fwd, 1'b0);
  endtask

  task automatic t_table;
    set_ent(0, UA, 1'b1, 1'b1);
    wr(7'h44, 32'h80);
    classify(UA, 1'b1, "R4 R3 exact match");
    classify(UA ^ 48'h1, 1'b0, "R4 byte5 differs");
    classify(UA ^ 48'h0200_0000_0000, 1'b0, "R3 byte0 differs");
    classify(UA ^ 48'h0000_0100_0000, 1'b0, "R3 byte2 differs");
  endtask

  task automatic t_flags;
    set_ent(1, UB, 1'b1, 1'b0);
    classify(UB, 1'b0, "R5 armed no forward");
    set_ent(1, UB, 1'b0, 1'b1);
    classify(UB, 1'b0, "R5 forward not armed");
    set_ent(1, UB, 1'b1, 1'b1);
    classify(UB, 1'b1, "R5 both flags");
  endtask

  task automatic t_tben;
    wr(7'h44, 32'h0);
    classify(UA, 1'b0, "R6 table off");
    wr(7'h44, 32'h80);
    classify(UA, 1'b1, "R6 table back on");
  endtask

  task automatic t_slot;
    set_ent(0, MA, 1'b1, 1'b1);
    classify(MA, 1'b0, "R7 group in unicast slot");
    classify(UA, 1'b0, "R7 old entry overwritten");
    set_ent(5, MA, 1'b1, 1'b1);
    classify(MA, 1'b1, "R7 group in group slot");
    set_ent(7, UC, 1'b1, 1'b1);
    classify(UC, 1'b0, "R7 unicast in group slot");
  endtask

  task automatic t_promisc;
    wr(7'h40, 32'h80);
    classify(UD, 1'b1, "R8 promisc unicast");
    classify(MB, 1'b1, "R8 promisc multicast");
    wr(7'h40, 32'h0);
    classify(UD, 1'b0, "R8 promisc off");
  endtask

  task automatic t_class;
    wr(7'h44, 32'h82);
    classify(UD, 1'b1, "R9 unicast pass");
    classify(MB, 1'b0, "R9 unicast switch ignores group");
    wr(7'h44, 32'h88);
    classify(MB, 1'b1, "R9 multicast pass");
    classify(BC, 1'b0, "R9 multicast excludes broadcast");
    classify(UD, 1'b0, "R9 multicast ignores unicast");
    wr(7'h44, 32'ha0);
    classify(BC, 1'b1, "R9 broadcast pass");
    classify(MB, 1'b0, "R9 broadcast ignores group");
    wr(7'h44, 32'h80);
  endtask

  task automatic t_same;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'h40; wr_data = 32'h80;
    da_valid = 1'b1; da = UD;
    @(negedge clk);
    wr_en = 1'b0; da_valid = 1'b0;
    chk("R10 same-cycle uses old state", fwd, 1'b0);
    classify(UD, 1'b1, "R10 next strobe uses new state");
    wr(7'h40, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_table();
    t_flags();
    t_tben();
    t_slot();
    t_promisc();
    t_class();
    t_same();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule